// File: doc/BRIEF.md
# Parallel-Compare Test Compression Unit

This block sits between the cycle decoder of a one-bit-wide DRAM and its storage array. It turns a normal single-cell access into a compressed access over eight array sections while a test mode is active. In normal operation, three address bits pick one of eight sections. Those bits are the top row bit, the top column bit and the lowest column bit. A write reaches only that section, and a read returns only that section's bit.

Once the decoder reports an entry cycle, the block enters the compressed test mode. An entry cycle is a CAS-before-RAS cycle with the write strobe held low. In this mode the three select bits are ignored, and every write lands in all eight sections at once. Every read collapses the eight fetched bits into one pass/fail bit: high when all eight agree, low when any one differs. The part can then be tested as a memory of one eighth the size.

Any refresh cycle reported by the decoder ends the mode. A refresh cycle here means a row-only refresh or a plain CAS-before-RAS refresh. Reads, writes, read-modify-writes and page-mode sequences are all accepted in either mode, because the block acts on one access strobe at a time.

Top module: `pcmp_test_unit`

## Requirements
- R1: While reset is low and in the first cycle after it, tmode_o, q_o and q_vld_o are 0.
- R2: A cycle with enter_i high makes tmode_o 1 from the next cycle on. If enter_i and exit_i are high together, enter_i takes priority.
- R3: A cycle with exit_i high and enter_i low makes tmode_o 0 from the next cycle on. When the block is already in normal mode, this has no effect.
- R4: The section index is {row_i[10], col_i[10], col_i[0]}, with row_i[10] as the most significant bit. In both modes, arr_addr_o = {row_i[9:0], col_i[9:1]}, with the row bits on top.
- R5: In normal mode, a cycle with wr_i high sets exactly bit "index" of arr_we_o in the same cycle. In every cycle, arr_wdata_o carries eight copies of din_i.
- R6: In test mode, a cycle with wr_i high sets all eight bits of arr_we_o, whatever the index bits are.
- R7: In normal mode, a cycle with rd_i high makes q_o equal arr_rdata_i[index] in the next cycle, with q_vld_o high for that one cycle.
- R8: In test mode, a cycle with rd_i high makes q_o 1 in the next cycle when all eight bits of arr_rdata_i are equal, and 0 when any bit differs. The index bits have no effect on this result.
- R9: When rd_i and wr_i are high in the same cycle, the write enables follow R5 or R6. The read result is taken from arr_rdata_i as it stands in that same cycle.
- R10: In a cycle with wr_i low, arr_we_o is all zero. In the cycle after one with rd_i low, q_vld_o is 0 and q_o keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| enter_i | input | 1 | Decoded test-mode entry cycle |
| exit_i | input | 1 | Decoded refresh cycle (row-only or plain CAS-before-RAS) |
| row_i | input | 11 | Latched row address |
| col_i | input | 11 | Latched column address |
| wr_i | input | 1 | Write strobe for this cycle |
| rd_i | input | 1 | Read strobe for this cycle |
| din_i | input | 1 | Data-in bit |
| arr_rdata_i | input | 8 | One bit fetched from each section |
| arr_addr_o | output | 19 | Address within a section |
| arr_we_o | output | 8 | Per-section write enables |
| arr_wdata_o | output | 8 | Per-section write data |
| q_o | output | 1 | Data out, or pass/fail in test mode |
| q_vld_o | output | 1 | q_o updated by a read in the previous cycle |
| tmode_o | output | 1 | Compressed test mode active |

## Verification
The case that is hardest to reach is a test-mode read where the eight fetched bits differ in exactly one position. Such a read must fail even when the addressed section holds the majority value. The stimulus reaches it by entering test mode and presenting eight patterns on arr_rdata_i, each with a single bit flipped. Each pattern is paired with an index that points away from the flipped bit. The bench also issues entry and exit in the same cycle, and a read-write cycle right after entry, to cover the mode-boundary ordering.

// File: rtl/pct_pkg.sv
package pct_pkg;
  typedef enum logic {
    PCT_NORMAL   = 1'b0,
    PCT_COMPRESS = 1'b1
  } pct_mode_e;

  // Number of address bits that pick a section; fixed by the 1-of-8 split.
  localparam int unsigned PCT_SEL_W = 3;
  localparam int unsigned PCT_NSEC  = 1 << PCT_SEL_W;
endpackage

// File: rtl/pct_mode_ctl.sv
module pct_mode_ctl
  import pct_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      enter_i,
  input  logic      exit_i,
  output pct_mode_e mode_o
);
  pct_mode_e mode_q;

  // Entry wins: an entry cycle is itself a refresh-class cycle.
  function automatic pct_mode_e next_mode(input pct_mode_e cur,
                                          input logic en, input logic ex);
    if (en)      return PCT_COMPRESS;
    else if (ex) return PCT_NORMAL;
    else         return cur;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= PCT_NORMAL;
    else        mode_q <= next_mode(mode_q, enter_i, exit_i);
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/pct_addr_split.sv
module pct_addr_split
  import pct_pkg::*;
#(
  parameter int unsigned ROW_W = 11,
  parameter int unsigned COL_W = 11,
  localparam int unsigned ADDR_W = (ROW_W - 1) + (COL_W - 2)
) (
  input  logic [ROW_W-1:0]     row_i,
  input  logic [COL_W-1:0]     col_i,
  output logic [PCT_SEL_W-1:0] sel_o,
  output logic [PCT_NSEC-1:0]  sel_onehot_o,
  output logic [ADDR_W-1:0]    addr_o
);
  function automatic logic [PCT_SEL_W-1:0] sect_index(
      input logic [ROW_W-1:0] r, input logic [COL_W-1:0] c);
    return {r[ROW_W-1], c[COL_W-1], c[0]};
  endfunction

  function automatic logic [ADDR_W-1:0] inner_addr(
      input logic [ROW_W-1:0] r, input logic [COL_W-1:0] c);
    return {r[ROW_W-2:0], c[COL_W-2:1]};
  endfunction

  assign sel_o  = sect_index(row_i, col_i);
  assign addr_o = inner_addr(row_i, col_i);

  for (genvar g = 0; g < PCT_NSEC; g++) begin : g_dec
    assign sel_onehot_o[g] = (sel_o == PCT_SEL_W'(g));
  end
endmodule

// File: rtl/pct_write_fan.sv
module pct_write_fan
  import pct_pkg::*;
(
  input  logic                wr_i,
  input  logic                din_i,
  input  pct_mode_e           mode_i,
  input  logic [PCT_NSEC-1:0] sel_onehot_i,
  output logic [PCT_NSEC-1:0] we_o,
  output logic [PCT_NSEC-1:0] wdata_o
);
  logic bcast;
  assign bcast = (mode_i == PCT_COMPRESS);

  for (genvar g = 0; g < PCT_NSEC; g++) begin : g_sec
    assign we_o[g]    = wr_i & (bcast | sel_onehot_i[g]);
    assign wdata_o[g] = din_i;
  end
endmodule

// File: rtl/pct_read_cmp.sv
module pct_read_cmp
  import pct_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_i,
  input  pct_mode_e            mode_i,
  input  logic [PCT_SEL_W-1:0] sel_i,
  input  logic [PCT_NSEC-1:0]  rdata_i,
  output logic                 q_o,
  output logic                 vld_o
);
  function automatic logic all_equal(input logic [PCT_NSEC-1:0] v);
    return (&v) | ~(|v);
  endfunction

  logic rd_bit;
  assign rd_bit = (mode_i == PCT_COMPRESS) ? all_equal(rdata_i) : rdata_i[sel_i];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_o   <= 1'b0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= rd_i;
      if (rd_i) q_o <= rd_bit;
    end
  end
endmodule

// File: rtl/pcmp_test_unit.sv
module pcmp_test_unit
  import pct_pkg::*;
#(
  parameter int unsigned ROW_W = 11,
  parameter int unsigned COL_W = 11,
  localparam int unsigned ADDR_W = (ROW_W - 1) + (COL_W - 2)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enter_i,
  input  logic                exit_i,
  input  logic [ROW_W-1:0]    row_i,
  input  logic [COL_W-1:0]    col_i,
  input  logic                wr_i,
  input  logic                rd_i,
  input  logic                din_i,
  input  logic [PCT_NSEC-1:0] arr_rdata_i,
  output logic [ADDR_W-1:0]   arr_addr_o,
  output logic [PCT_NSEC-1:0] arr_we_o,
  output logic [PCT_NSEC-1:0] arr_wdata_o,
  output logic                q_o,
  output logic                q_vld_o,
  output logic                tmode_o
);
  pct_mode_e            mode;
  logic [PCT_SEL_W-1:0] sel;
  logic [PCT_NSEC-1:0]  sel_onehot;

  pct_mode_ctl u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .enter_i (enter_i),
    .exit_i  (exit_i),
    .mode_o  (mode)
  );

  pct_addr_split #(.ROW_W(ROW_W), .COL_W(COL_W)) u_split (
    .row_i        (row_i),
    .col_i        (col_i),
    .sel_o        (sel),
    .sel_onehot_o (sel_onehot),
    .addr_o       (arr_addr_o)
  );

  pct_write_fan u_wfan (
    .wr_i         (wr_i),
    .din_i        (din_i),
    .mode_i       (mode),
    .sel_onehot_i (sel_onehot),
    .we_o         (arr_we_o),
    .wdata_o      (arr_wdata_o)
  );

  pct_read_cmp u_rcmp (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_i    (rd_i),
    .mode_i  (mode),
    .sel_i   (sel),
    .rdata_i (arr_rdata_i),
    .q_o     (q_o),
    .vld_o   (q_vld_o)
  );

  assign tmode_o = (mode == PCT_COMPRESS);
endmodule

// File: rtl/pct_checks.sv
module pct_checks
  import pct_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                enter_i,
  input logic                exit_i,
  input logic                wr_i,
  input logic                rd_i,
  input logic [PCT_NSEC-1:0] arr_rdata_i,
  input logic [PCT_NSEC-1:0] arr_we_o,
  input logic                q_o,
  input logic                q_vld_o,
  input logic                tmode_o
);
  a_r2_enter: assert property (@(posedge clk) disable iff (!rst_n)
    enter_i |=> tmode_o);

  a_r3_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (exit_i && !enter_i) |=> !tmode_o);

  a_r5_one_section: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !tmode_o) |-> ($countones(arr_we_o) == 1));

  a_r6_all_sections: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && tmode_o) |-> (arr_we_o == {PCT_NSEC{1'b1}}));

  a_r8_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && tmode_o && ((arr_rdata_i == '0) || (arr_rdata_i == '1))) |=> q_o);

  a_r8_fail: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && tmode_o && (arr_rdata_i != '0) && (arr_rdata_i != '1)) |=> !q_o);

  a_r10_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |-> (arr_we_o == '0));

  a_r10_hold_q: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> (!q_vld_o && $stable(q_o)));

  a_r7_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |=> q_vld_o);
endmodule

bind pcmp_test_unit pct_checks u_pct_checks (
  .clk         (clk),
  .rst_n       (rst_n),
  .enter_i     (enter_i),
  .exit_i      (exit_i),
  .wr_i        (wr_i),
  .rd_i        (rd_i),
  .arr_rdata_i (arr_rdata_i),
  .arr_we_o    (arr_we_o),
  .q_o         (q_o),
  .q_vld_o     (q_vld_o),
  .tmode_o     (tmode_o)
);

// File: tb/test_pcmp_test_unit.sv
`timescale 1ns/1ps
module test_pcmp_test_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enter_i = 1'b0, exit_i = 1'b0;
  logic [10:0] row_i = '0, col_i = '0;
  logic        wr_i = 1'b0, rd_i = 1'b0, din_i = 1'b0;
  logic [7:0]  arr_rdata_i = '0;
  logic [18:0] arr_addr_o;
  logic [7:0]  arr_we_o, arr_wdata_o;
  logic        q_o, q_vld_o, tmode_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  bit m_mode = 0;
  bit m_q = 0;
  bit m_vld = 0;

  always #10 clk = ~clk;

  pcmp_test_unit i_pcmp_test_unit (
    .clk(clk), .rst_n(rst_n), .enter_i(enter_i), .exit_i(exit_i),
    .row_i(row_i), .col_i(col_i), .wr_i(wr_i), .rd_i(rd_i), .din_i(din_i),
    .arr_rdata_i(arr_rdata_i), .arr_addr_o(arr_addr_o), .arr_we_o(arr_we_o),
    .arr_wdata_o(arr_wdata_o), .q_o(q_o), .q_vld_o(q_vld_o), .tmode_o(tmode_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int idx_of(input logic [10:0] r, input logic [10:0] c);
    return (r[10] ? 4 : 0) + (c[10] ? 2 : 0) + (c[0] ? 1 : 0);
  endfunction

  function automatic int ones(input logic [7:0] v);
    int n = 0;
    for (int i = 0; i < 8; i++) if (v[i]) n++;
    return n;
  endfunction

  // One clock of stimulus; inputs change one ns after a rising edge.
  task automatic cyc(input bit en, input bit ex, input bit wr, input bit rd,
                     input bit d, input logic [10:0] r, input logic [10:0] c,
                     input logic [7:0] rdat);
    int idx, exp_we, exp_addr;
    enter_i = en; exit_i = ex; wr_i = wr; rd_i = rd; din_i = d;
    row_i = r; col_i = c; arr_rdata_i = rdat;
    #1;
    idx = idx_of(r, c);
    exp_addr = (int'(r) % 1024) * 512 + (int'(c) / 2) % 512;
    exp_we = !wr ? 0 : (m_mode ? 255 : (1 << idx));
    check("R4 addr", int'(arr_addr_o), exp_addr);
    if (!wr)         check("R10 we idle", int'(arr_we_o), exp_we);
    else if (m_mode) check("R6 we bcast", int'(arr_we_o), exp_we);
    else             check("R5 we one", int'(arr_we_o), exp_we);
    check("R5 wdata", int'(arr_wdata_o), d ? 255 : 0);
    @(posedge clk);
    if (rd) begin
      m_q = m_mode ? ((ones(rdat) == 0) || (ones(rdat) == 8)) : rdat[idx];
      m_vld = 1;
    end else m_vld = 0;
    if (en) m_mode = 1;
    else if (ex) m_mode = 0;
    #1;
    check(en ? "R2 mode" : "R3 mode", int'(tmode_o), int'(m_mode));
    check(m_mode ? "R8 q" : "R7 q", int'(q_o), int'(m_q));
    check(rd ? "R7 vld" : "R10 vld", int'(q_vld_o), int'(m_vld));
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [10:0] r, c;
    logic [7:0] v;
    #35;
    check("R1 tmode in reset", int'(tmode_o), 0);
    check("R1 q in reset", int'(q_o), 0);
    check("R1 vld in reset", int'(q_vld_o), 0);
    @(posedge clk); #1; rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 tmode after", int'(tmode_o), 0);
    check("R1 vld after", int'(q_vld_o), 0);

    // normal writes to each section (R5, R4)
    for (int s = 0; s < 8; s++) begin
      r = 11'($urandom); c = 11'($urandom);
      r[10] = s[2]; c[10] = s[1]; c[0] = s[0];
      cyc(0, 0, 1, 0, s[0], r, c, 8'h00);
    end
    // normal reads of each section against a walking pattern (R7)
    for (int s = 0; s < 8; s++) begin
      r = 11'($urandom); c = 11'($urandom);
      r[10] = s[2]; c[10] = s[1]; c[0] = s[0];
      cyc(0, 0, 0, 1, 0, r, c, 8'(1 << s));
      cyc(0, 0, 0, 1, 0, r, c, ~8'(1 << s));
      cyc(0, 0, 0, 0, 0, r, c, 8'(1 << s)); // R10 hold
    end
    // exit in normal mode has no effect (R3)
    cyc(0, 1, 0, 0, 0, 11'h0, 11'h0, 8'h00);
    // enter, then read-write in the first test cycle (R2, R9)
    cyc(1, 0, 0, 0, 0, 11'h7ff, 11'h401, 8'h00);
    cyc(0, 0, 1, 1, 1, 11'h7ff, 11'h401, 8'hff);
    // test writes, any index (R6)
    for (int s = 0; s < 8; s++) cyc(0, 0, 1, 0, s[1], 11'($urandom), 11'($urandom), 8'h00);
    // test reads: uniform passes, single-bit mismatch fails (R8)
    cyc(0, 0, 0, 1, 0, 11'h123, 11'h456, 8'h00);
    cyc(0, 0, 0, 1, 0, 11'h123, 11'h457, 8'hff);
    for (int s = 0; s < 8; s++) begin
      r = 11'($urandom); c = 11'($urandom);
      v = 8'(1 << s);
      r[10] = ~s[2]; c[10] = s[1]; c[0] = ~s[0];
      cyc(0, 0, 0, 1, 0, r, c, v);
      cyc(0, 0, 0, 1, 0, r, c, ~v);
    end
    // enter and exit together: enter wins (R2), then exit (R3)
    cyc(1, 1, 0, 0, 0, 11'h0, 11'h0, 8'h00);
    cyc(0, 1, 0, 1, 0, 11'h0, 11'h0, 8'hfe);
    cyc(0, 0, 0, 1, 0, 11'h0, 11'h0, 8'hfe);

    // random mix (R2..R10)
    for (int k = 0; k < 400; k++) begin
      int p = $urandom % 32;
      v = 8'($urandom);
      if (($urandom % 3) == 0) v = ($urandom % 2) ? 8'hff : 8'h00;
      cyc(p == 0, p == 1 || p == 2, 1'($urandom), 1'($urandom), 1'($urandom),
          11'($urandom), 11'($urandom), v);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule